// File: doc/BRIEF.md
# Chip Idle Handshake Sequencer

This block brings a dual-processor chip into its deepest low-power state in a fixed order and takes it out again in the reverse order. The host writes a 12-bit control word that holds per-peripheral clock-idle enables, a PLL-idle permission and a self-setting idle command. Once the command is latched and no wake-up is pending, the sequencer raises its host-domain idle request. It waits until both the host domain and the DSP domain acknowledge idle, then asks the traffic controller to idle, then the clock-generator PLLs, and finally raises a chip-idle flag. That flag tells the board it may stop the chip's input clock.

Each wait for an acknowledge is bounded by a programmable cycle limit. When the limit runs out, the sequencer drops every request, returns to its running state and raises a sticky error. An active-low wake-up input blocks entry while it is low. It also aborts any stage in progress. The abort clears the chip-idle flag, releases the PLLs, then the traffic controller once the PLLs have let go, then the domains once the traffic controller has let go.

All acknowledge inputs and the wake-up input come from other clock or power domains. They pass through two-flop synchronisers before the sequencer uses them.

Top module: `chip_idle_seq`

## Requirements
- R1: After reset, all request outputs, `periph_clk_idle`, `chip_idle` and `timeout_err` are low.
- R2: A write of `ctrl_wdata` stores bits [7:0] as peripheral idle enables and bit 8 as the PLL-idle permission. A 1 in bit 11 latches the idle command, so writing 0x0FFF sets all three at once. The command starts entry only while the synchronised wake-up is high. While wake-up is low, `host_idle_req` stays low.
- R3: `periph_clk_idle[i]` equals enable bit i AND the synchronised host idle acknowledge. A change on `host_idle_ack` reaches it after exactly two rising edges.
- R4: `tc_idle_req` rises only after both `host_idle_ack` and `dsp_idle_ack` are high.
- R5: `pll_idle_req` (all bits) rises only after `tc_idle_ack` is high and the PLL permission is set. With the permission clear, the sequence holds with the traffic controller idle, raises no PLL request and never times out.
- R6: `chip_idle` rises only when every `pll_idle_ack` bit is high and wake-up is high.
- R7: On wake-up low during entry, `chip_idle` and `pll_idle_req` fall on the third rising edge after the pin falls. `tc_idle_req` is held until all PLL acks are low. `host_idle_req` is held until `tc_idle_ack` is low. The idle command is then cleared, so entry does not restart on its own.
- R8: With `timeout_limit` = L > 0, an acknowledge wait of L+1 cycles drops all requests and sets `timeout_err`. L = 0 disables the timeout.
- R9: `timeout_err` stays set until reset, including across a later successful entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 12 | Control word write data |
| timeout_limit | input | 8 | Acknowledge wait limit in cycles, 0 = no limit |
| host_idle_ack | input | 1 | Host domain reports idle (asynchronous) |
| dsp_idle_ack | input | 1 | DSP domain reports idle (asynchronous) |
| tc_idle_ack | input | 1 | Traffic controller reports idle (asynchronous) |
| pll_idle_ack | input | 3 | Per-PLL idle report (asynchronous) |
| wake_n | input | 1 | Active-low wake-up request (asynchronous) |
| host_idle_req | output | 1 | Host domain idle request |
| periph_clk_idle | output | 8 | Per-peripheral clock idle permission |
| tc_idle_req | output | 1 | Traffic controller idle request |
| pll_idle_req | output | 3 | Per-PLL idle request |
| chip_idle | output | 1 | Input clock may be stopped |
| timeout_err | output | 1 | Sticky acknowledge timeout flag |

## Verification
If the state register left its one-hot encoding or skipped a stage, a request would appear before its predecessor's acknowledge. A wrongly decoded state would show on the request pins at the next edge, because every request is a flop loaded from the next-state decode. A broken abort path shows within three edges of wake-up falling: `chip_idle` stays high, or a later-stage request outlives an earlier one. A bad timeout counter shifts the edge where `timeout_err` rises away from L+1 cycles after the request, so the bench sweeps several limits and checks the edges on both sides.

// File: rtl/cis_pkg.sv
package cis_pkg;
   localparam int CTRL_W      = 12;
   localparam int BIT_PLL_EN  = 8;
   localparam int BIT_IDLE_GO = 11;
   localparam int MAX_PERIPH  = 8;

   typedef enum logic [5:0] {
      ST_RUN   = 6'b000001,
      ST_DOM   = 6'b000010,
      ST_TC    = 6'b000100,
      ST_PLL   = 6'b001000,
      ST_CHIP  = 6'b010000,
      ST_WAKE  = 6'b100000
   } seq_state_t;
endpackage

// File: rtl/cis_sync.sv
module cis_sync #(
   parameter int  W       = 1,
   parameter int  STAGES  = 2,
   parameter bit  RST_VAL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cis_sync needs at least two stages");
      end
      if (W < 1) begin : g_bad_width
         $error("cis_sync needs a positive width");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= {W{RST_VAL}};
      else        chain[0] <= d;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= {W{RST_VAL}};
            else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cis_ctrl.sv
module cis_ctrl
   import cis_pkg::*;
#(
   parameter int NUM_PERIPH = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr,
   input  logic [CTRL_W-1:0]     wdata,
   input  logic                  go_clr,
   input  logic                  host_idle_s,
   output logic                  idle_go,
   output logic                  pll_en,
   output logic [NUM_PERIPH-1:0] periph_clk_idle
);
   logic [NUM_PERIPH-1:0] periph_en;

   generate
      if (NUM_PERIPH < 1 || NUM_PERIPH > MAX_PERIPH) begin : g_bad_periph
         $error("NUM_PERIPH must lie in 1..8");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         periph_en <= '0;
         pll_en    <= 1'b0;
         idle_go   <= 1'b0;
      end else begin
         if (wr) begin
            periph_en <= wdata[NUM_PERIPH-1:0];
            pll_en    <= wdata[BIT_PLL_EN];
         end
         if (wr && wdata[BIT_IDLE_GO]) idle_go <= 1'b1;
         else if (go_clr)              idle_go <= 1'b0;
      end
   end

   generate
      for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_periph
         assign periph_clk_idle[i] = periph_en[i] & host_idle_s;
      end
   endgenerate

   assert_idle_go_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wdata[BIT_IDLE_GO]) |=> idle_go);
endmodule

// File: rtl/cis_fsm.sv
module cis_fsm
   import cis_pkg::*;
#(
   parameter int NUM_PLL = 3,
   parameter int TO_W    = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               idle_go,
   input  logic               pll_en,
   input  logic [TO_W-1:0]    timeout_limit,
   input  logic               host_s,
   input  logic               dsp_s,
   input  logic               tc_s,
   input  logic [NUM_PLL-1:0] pll_s,
   input  logic               wake_s,
   output logic               go_clr,
   output logic               host_idle_req,
   output logic               tc_idle_req,
   output logic [NUM_PLL-1:0] pll_idle_req,
   output logic               chip_idle,
   output logic               timeout_err
);
   seq_state_t          st, nxt;
   logic [TO_W-1:0]     wait_cnt;
   logic                waiting, expire, set_err;
   logic                pll_req_q, tc_req_q, dom_req_q, err_q;
   logic                all_pll, any_pll;

   generate
      if (TO_W < 2)    begin : g_bad_tow  $error("TO_W must be at least 2"); end
      if (NUM_PLL < 1) begin : g_bad_npll $error("NUM_PLL must be positive"); end
   endgenerate

   assign all_pll = &pll_s;
   assign any_pll = |pll_s;

   assign waiting = (st == ST_DOM) || (st == ST_TC && !tc_s) ||
                    (st == ST_PLL && !all_pll);
   assign expire  = waiting && (timeout_limit != '0) && (wait_cnt == timeout_limit);

   always_comb begin
      nxt     = st;
      go_clr  = 1'b0;
      set_err = 1'b0;
      unique case (st)
         ST_RUN:  if (idle_go && wake_s) nxt = ST_DOM;
         ST_DOM: begin
            if (!wake_s)              nxt = ST_WAKE;
            else if (expire)          begin nxt = ST_RUN; set_err = 1'b1; go_clr = 1'b1; end
            else if (host_s && dsp_s) nxt = ST_TC;
         end
         ST_TC: begin
            if (!wake_s)              nxt = ST_WAKE;
            else if (expire)          begin nxt = ST_RUN; set_err = 1'b1; go_clr = 1'b1; end
            else if (tc_s && pll_en)  nxt = ST_PLL;
         end
         ST_PLL: begin
            if (!wake_s)              nxt = ST_WAKE;
            else if (expire)          begin nxt = ST_RUN; set_err = 1'b1; go_clr = 1'b1; end
            else if (all_pll)         nxt = ST_CHIP;
         end
         ST_CHIP: if (!wake_s) nxt = ST_WAKE;
         ST_WAKE: begin
            if (!pll_req_q && !any_pll && !tc_req_q && !tc_s) begin
               nxt    = ST_RUN;
               go_clr = 1'b1;
            end
         end
         default: nxt = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_RUN;
         wait_cnt  <= '0;
         pll_req_q <= 1'b0;
         tc_req_q  <= 1'b0;
         dom_req_q <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         st    <= nxt;
         err_q <= err_q | set_err;
         if (!waiting || nxt != st) wait_cnt <= '0;
         else                       wait_cnt <= wait_cnt + 1'b1;
         pll_req_q <= (nxt == ST_PLL) || (nxt == ST_CHIP);
         if (nxt == ST_WAKE) begin
            tc_req_q  <= tc_req_q && (pll_req_q || any_pll);
            dom_req_q <= dom_req_q && (tc_req_q || tc_s);
         end else begin
            tc_req_q  <= (nxt == ST_TC) || (nxt == ST_PLL) || (nxt == ST_CHIP);
            dom_req_q <= (nxt != ST_RUN);
         end
      end
   end

   assign host_idle_req = dom_req_q;
   assign tc_idle_req   = tc_req_q;
   assign pll_idle_req  = {NUM_PLL{pll_req_q}};
   assign chip_idle     = st[4];
   assign timeout_err   = err_q;

   assert_state_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(st));
   assert_tc_after_domains_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc_req_q) |-> $past(host_s && dsp_s));
   assert_pll_after_tc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_req_q) |-> $past(tc_s && pll_en));
   assert_chip_after_plls_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chip_idle) |-> $past(all_pll && wake_s));
   assert_wake_drops_chip_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wake_s |=> !chip_idle);
   assert_tc_release_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tc_req_q) |-> !pll_req_q);
   assert_dom_release_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dom_req_q) |-> !tc_req_q);
   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);
endmodule

// File: rtl/chip_idle_seq.sv
module chip_idle_seq
   import cis_pkg::*;
#(
   parameter int NUM_PLL     = 3,
   parameter int NUM_PERIPH  = 8,
   parameter int SYNC_STAGES = 2,
   parameter int TO_W        = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ctrl_wr,
   input  logic [CTRL_W-1:0]     ctrl_wdata,
   input  logic [TO_W-1:0]       timeout_limit,
   input  logic                  host_idle_ack,
   input  logic                  dsp_idle_ack,
   input  logic                  tc_idle_ack,
   input  logic [NUM_PLL-1:0]    pll_idle_ack,
   input  logic                  wake_n,
   output logic                  host_idle_req,
   output logic [NUM_PERIPH-1:0] periph_clk_idle,
   output logic                  tc_idle_req,
   output logic [NUM_PLL-1:0]    pll_idle_req,
   output logic                  chip_idle,
   output logic                  timeout_err
);
   localparam int ACK_W = NUM_PLL + 3;

   logic [ACK_W-1:0]   ack_s;
   logic               wake_s, idle_go, pll_en, go_clr;

   cis_sync #(.W(ACK_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ack_sync (
      .clk (clk), .rst_n (rst_n),
      .d   ({pll_idle_ack, tc_idle_ack, dsp_idle_ack, host_idle_ack}),
      .q   (ack_s)
   );

   cis_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_wake_sync (
      .clk (clk), .rst_n (rst_n), .d (wake_n), .q (wake_s)
   );

   cis_ctrl #(.NUM_PERIPH(NUM_PERIPH)) u_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .wr              (ctrl_wr),
      .wdata           (ctrl_wdata),
      .go_clr          (go_clr),
      .host_idle_s     (ack_s[0]),
      .idle_go         (idle_go),
      .pll_en          (pll_en),
      .periph_clk_idle (periph_clk_idle)
   );

   cis_fsm #(.NUM_PLL(NUM_PLL), .TO_W(TO_W)) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .idle_go       (idle_go),
      .pll_en        (pll_en),
      .timeout_limit (timeout_limit),
      .host_s        (ack_s[0]),
      .dsp_s         (ack_s[1]),
      .tc_s          (ack_s[2]),
      .pll_s         (ack_s[ACK_W-1:3]),
      .wake_s        (wake_s),
      .go_clr        (go_clr),
      .host_idle_req (host_idle_req),
      .tc_idle_req   (tc_idle_req),
      .pll_idle_req  (pll_idle_req),
      .chip_idle     (chip_idle),
      .timeout_err   (timeout_err)
   );
endmodule

// File: tb/tb_chip_idle_seq.sv
module tb_chip_idle_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_wr = 1'b0;
   logic [11:0] ctrl_wdata = '0;
   logic [7:0]  timeout_limit = '0;
   logic        host_idle_ack = 1'b0, dsp_idle_ack = 1'b0, tc_idle_ack = 1'b0;
   logic [2:0]  pll_idle_ack = '0;
   logic        wake_n = 1'b1;
   logic        host_idle_req, tc_idle_req, chip_idle, timeout_err;
   logic [7:0]  periph_clk_idle;
   logic [2:0]  pll_idle_req;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   chip_idle_seq dut (
      .clk (clk), .rst_n (rst_n), .ctrl_wr (ctrl_wr), .ctrl_wdata (ctrl_wdata),
      .timeout_limit (timeout_limit), .host_idle_ack (host_idle_ack),
      .dsp_idle_ack (dsp_idle_ack), .tc_idle_ack (tc_idle_ack),
      .pll_idle_ack (pll_idle_ack), .wake_n (wake_n),
      .host_idle_req (host_idle_req), .periph_clk_idle (periph_clk_idle),
      .tc_idle_req (tc_idle_req), .pll_idle_req (pll_idle_req),
      .chip_idle (chip_idle), .timeout_err (timeout_err)
   );

   task automatic step(input int n);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] v);
      ctrl_wr = 1'b1; ctrl_wdata = v;
      step(1);
      ctrl_wr = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; step(3); rst_n = 1'b1; step(3);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      step(1);
      do_reset();
      // R1 reset state
      check("R1 host_req", host_idle_req, 0);
      check("R1 tc_req", tc_idle_req, 0);
      check("R1 pll_req", pll_idle_req, 0);
      check("R1 chip", chip_idle, 0);
      check("R1 err", timeout_err, 0);
      check("R1 periph", periph_clk_idle, 0);

      // R3 exhaustive enable sweep with host ack high
      host_idle_ack = 1'b1; step(3);
      for (int v = 0; v < 256; v++) begin
         wr(12'(v));
         check("R3 periph sweep", periph_clk_idle, v);
      end
      host_idle_ack = 1'b0;
      step(1); check("R3 sync edge1", periph_clk_idle, 8'hFF);
      step(1); check("R3 sync edge2", periph_clk_idle, 8'h00);
      check("R2 no command bit", host_idle_req, 0);

      // R2 wake low blocks entry
      wake_n = 1'b0; step(3);
      wr(12'h0FFF); step(5);
      check("R2 blocked by wake", host_idle_req, 0);
      wake_n = 1'b1; step(4);
      check("R2 0x0FFF starts entry", host_idle_req, 1);

      // R4 both domains needed
      host_idle_ack = 1'b1; step(6);
      check("R4 host only", tc_idle_req, 0);
      check("R3 periph with host idle", periph_clk_idle, 8'hFF);
      dsp_idle_ack = 1'b1; step(4);
      check("R4 both domains", tc_idle_req, 1);
      check("R5 pll before tc ack", pll_idle_req, 0);
      check("R8 limit zero no timeout", timeout_err, 0);

      // R5 PLL request after TC ack
      tc_idle_ack = 1'b1; step(4);
      check("R5 pll req", pll_idle_req, 3'b111);
      check("R6 chip before plls", chip_idle, 0);

      // R6 all PLL acks needed
      pll_idle_ack = 3'b011; step(6);
      check("R6 partial plls", chip_idle, 0);
      pll_idle_ack = 3'b111; step(4);
      check("R6 chip idle", chip_idle, 1);

      // R7 abort and reverse release
      wake_n = 1'b0;
      step(2); check("R7 chip edge2", chip_idle, 1);
      step(1); check("R7 chip edge3", chip_idle, 0);
      check("R7 pll released first", pll_idle_req, 0);
      check("R7 tc held", tc_idle_req, 1);
      step(8); check("R7 tc held while pll acks", tc_idle_req, 1);
      pll_idle_ack = '0; step(4);
      check("R7 tc released", tc_idle_req, 0);
      check("R7 host held", host_idle_req, 1);
      step(8); check("R7 host held while tc ack", host_idle_req, 1);
      tc_idle_ack = 1'b0; step(4);
      check("R7 host released", host_idle_req, 0);
      wake_n = 1'b1; step(10);
      check("R7 command cleared", host_idle_req, 0);

      // R5 PLL permission clear holds at TC, no timeout
      timeout_limit = 8'd4;
      tc_idle_ack = 1'b1; step(3);
      wr(12'h08FF); step(30);
      check("R5 hold tc", tc_idle_req, 1);
      check("R5 no pll", pll_idle_req, 0);
      check("R5 no timeout when held", timeout_err, 0);
      wake_n = 1'b0; tc_idle_ack = 1'b0; step(8);
      check("R7 release from tc", host_idle_req, 0);
      wake_n = 1'b1; host_idle_ack = 1'b0; dsp_idle_ack = 1'b0; step(4);

      // R8 timeout sweep
      for (int L = 1; L <= 5; L++) begin
         do_reset();
         timeout_limit = 8'(L);
         wr(12'h0FFF);
         step(1); check("R8 req up", host_idle_req, 1);
         step(L);
         check("R8 no err before limit", timeout_err, 0);
         check("R8 req kept before limit", host_idle_req, 1);
         step(1);
         check("R8 err at limit", timeout_err, 1);
         check("R8 req dropped", host_idle_req, 0);
      end

      // R9 sticky across a successful entry
      timeout_limit = 8'd0;
      host_idle_ack = 1'b1; dsp_idle_ack = 1'b1; tc_idle_ack = 1'b1; pll_idle_ack = 3'b111;
      step(3);
      wr(12'h0FFF); step(10);
      check("R9 entry completes", chip_idle, 1);
      check("R9 err sticky", timeout_err, 1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule